// File: doc/BRIEF.md
# Fuse Array Protected-Read Controller

This block sits between a 32-bit register bus and a small one-time-programmable fuse array, modelled here as a shadow register file with a configurable access latency. Software can reach fuse words in two ways. Words below a protected boundary can be read directly through a memory-mapped window. All words, including the protected ones, can be reached through a keyed indirect sequence. Software writes a control register holding a byte offset, an unlock key and a request bit. The hardware performs the access and then clears the request bit by itself.

A read request places the fetched word in a read-data register. A program request ORs the contents of a program-data register into the selected word, so bits can only ever go from 0 to 1. Software polls the control register until both request bits read as zero. While an access is in flight, the controller ignores any further control writes.

Top module: `fusectl_top`

## Requirements
- R1: After reset, the control register (byte address 0x40), the program-data register (0x50) and the read-data register (0x60) all read as zero. The program-data register is read/write.
- R2: A read at byte address 0x200 + 4*w returns fuse word w when w is below the protected boundary (32 by default). Fuse byte o holds ((o*37) mod 256) XOR 0xA5 out of reset. Word w packs bytes 4w..4w+3 with byte 4w in bits 7:0 (little-endian).
- R3: Window reads of words at or above the protected boundary (words 32..63 by default) return zero.
- R4: Control register fields are: bits 23:16 the fuse byte offset, bits 15:8 the key, bit 1 the read request, bit 0 the program request. The offset and key fields read back as last accepted.
- R5: A control write whose key is 0xAC and whose bit 1 is set starts an indirect read of word offset[7:2]; offset bits 1:0 are ignored. Bit 1 reads as set for exactly LAT cycles after the write (default 8) and then clears. At that point 0x60 holds the word, for protected and public words alike.
- R6: A control write whose key is not 0xAC starts nothing. Both request bits read back as zero at once, and the read-data register is unchanged.
- R7: While a request is in flight, a control write is ignored entirely: fields, request bits and timing are unchanged.
- R8: A control write with key 0xAC and only bit 0 set ORs the program-data register into word offset[7:2]. Bit 0 stays set for LAT cycles. The result is visible afterwards through the window and through indirect reads.
- R9: When bits 1 and 0 are both set with a valid key, only the read is performed and the fuse word is not modified.
- R10: Writes to 0x60 and to the direct window have no effect. Reads of any unmapped address return zero.
- R11: A read request returns its data with the read-valid output asserted on the cycle after the request. A write produces no read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |

## Verification
The hardest case to reach is a control write that lands while an earlier indirect access is still counting down. It is hard because the window is only LAT cycles wide and the bench sees the busy state only by polling. The bench issues a keyed read and then, on the very next bus cycle, a second keyed control write with a different offset. It then polls back-to-back and checks three things: the busy count is one short of LAT, the fields still hold the first offset, and the fetched word belongs to the first request. A similar timing-exact poll after program requests shows the OR result in both the window and an indirect read of a protected word.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;
  localparam int unsigned CTRL_OFS  = 'h40;
  localparam int unsigned PDATA_OFS = 'h50;
  localparam int unsigned RDKEY_OFS = 'h60;
  localparam int unsigned WIN_OFS   = 'h200;

  localparam logic [7:0] UNLOCK_KEY = 8'hAC;
  localparam int unsigned BIT_PROG  = 0;
  localparam int unsigned BIT_READ  = 1;
  localparam int unsigned KEY_LSB   = 8;
  localparam int unsigned OFS_LSB   = 16;

  typedef struct packed {
    logic [7:0] ofs;
    logic [7:0] key;
  } ctrl_fields_t;

  function automatic logic [7:0] init_byte(int unsigned o, logic [7:0] seed);
    logic [7:0] t;
    t = 8'((o * 37) % 256);
    return t ^ seed;
  endfunction

  function automatic logic [31:0] init_word(int unsigned w, logic [7:0] seed);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = init_byte(4 * w + 32'(b), seed);
    return r;
  endfunction
endpackage

// File: rtl/fusectl_array.sv
module fusectl_array
  import fusectl_pkg::*;
#(
  parameter int unsigned WORDS      = 64,
  parameter int unsigned LAT        = 8,
  parameter int unsigned PROT_FIRST = 32,
  parameter logic [7:0]  SEED       = 8'hA5,
  localparam int unsigned IDX_W     = $clog2(WORDS),
  localparam int unsigned CNT_W     = $clog2(LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] win_idx_i,
  output logic [31:0]      win_data_o,
  input  logic             start_i,
  input  logic             prog_i,
  input  logic [IDX_W-1:0] op_idx_i,
  input  logic [31:0]      pdata_i,
  output logic             done_o,
  output logic [31:0]      op_data_o
);
  localparam logic [IDX_W:0] PROT_LIM = (IDX_W + 1)'(PROT_FIRST);

  logic [31:0]      mem_q [WORDS];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             prog_q;
  logic [31:0]      pdata_q;

  assign done_o     = (cnt_q == CNT_W'(1));
  assign op_data_o  = mem_q[idx_q];
  assign win_data_o = ({1'b0, win_idx_i} >= PROT_LIM) ? 32'h0 : mem_q[win_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      prog_q  <= 1'b0;
      pdata_q <= '0;
    end else if (start_i && cnt_q == '0) begin
      cnt_q   <= CNT_W'(LAT);
      idx_q   <= op_idx_i;
      prog_q  <= prog_i;
      pdata_q <= pdata_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // fuse semantics: programming can only set bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < int'(WORDS); w++) mem_q[w] <= init_word(32'(w), SEED);
    end else if (done_o && prog_q) begin
      mem_q[idx_q] <= mem_q[idx_q] | pdata_q;
    end
  end
endmodule

// File: rtl/fusectl_seq.sv
module fusectl_seq
  import fusectl_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             pdata_we_i,
  input  logic [31:0]      wdata_i,
  input  logic             done_i,
  input  logic [31:0]      op_data_i,
  output logic             start_o,
  output logic             prog_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [31:0]      pdata_o,
  output logic [31:0]      rdkey_o,
  output logic [31:0]      ctrl_rd_o,
  output logic             rd_busy_o,
  output logic             wr_busy_o,
  output ctrl_fields_t     fields_o
);
  logic rd_busy_q, wr_busy_q;
  logic busy, accept, key_ok, want_rd, want_wr;
  ctrl_fields_t fields_q;
  logic [31:0] pdata_q, rdkey_q;

  assign busy    = rd_busy_q | wr_busy_q;
  assign accept  = ctrl_we_i & ~busy;
  assign key_ok  = (wdata_i[KEY_LSB +: 8] == UNLOCK_KEY);
  assign want_rd = wdata_i[BIT_READ];
  assign want_wr = wdata_i[BIT_PROG];
  assign start_o = accept & key_ok & (want_rd | want_wr);
  assign prog_o  = ~want_rd;  // read wins when both are requested
  assign idx_o   = wdata_i[OFS_LSB + 2 +: IDX_W];

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:24], wdata_i[7:2], wdata_i[17:16]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_busy_q <= 1'b0;
      wr_busy_q <= 1'b0;
      fields_q  <= '0;
      rdkey_q   <= '0;
    end else if (accept) begin
      fields_q  <= '{ofs: wdata_i[OFS_LSB +: 8], key: wdata_i[KEY_LSB +: 8]};
      rd_busy_q <= start_o & want_rd;
      wr_busy_q <= start_o & ~want_rd;
    end else if (done_i) begin
      rd_busy_q <= 1'b0;
      wr_busy_q <= 1'b0;
      if (rd_busy_q) rdkey_q <= op_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pdata_q <= '0;
    else if (pdata_we_i) pdata_q <= wdata_i;
  end

  assign pdata_o   = pdata_q;
  assign rdkey_o   = rdkey_q;
  assign rd_busy_o = rd_busy_q;
  assign wr_busy_o = wr_busy_q;
  assign fields_o  = fields_q;
  assign ctrl_rd_o = {8'h00, fields_q.ofs, fields_q.key, 6'h00, rd_busy_q, wr_busy_q};
endmodule

// File: rtl/fusectl_bus.sv
module fusectl_bus
  import fusectl_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORDS  = 64,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       ctrl_rd_i,
  input  logic [31:0]       pdata_i,
  input  logic [31:0]       rdkey_i,
  input  logic [31:0]       win_data_i,
  output logic              ctrl_we_o,
  output logic              pdata_we_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o
);
  localparam int unsigned WB = WIN_OFS / 4;

  logic [31:0] wa;
  logic sel_ctrl, sel_pdata, sel_rdkey, sel_win, rd_req;
  logic [31:0] rmux;
  logic rvalid_q;
  logic [31:0] rdata_q;

  assign wa        = 32'(addr_i[ADDR_W-1:2]);
  assign sel_ctrl  = (wa == CTRL_OFS / 4);
  assign sel_pdata = (wa == PDATA_OFS / 4);
  assign sel_rdkey = (wa == RDKEY_OFS / 4);
  assign sel_win   = (wa >= WB) && (wa < WB + WORDS);
  assign win_idx_o = IDX_W'(wa - WB);

  logic unused_addr;
  assign unused_addr = ^addr_i[1:0];

  assign ctrl_we_o  = req_i & we_i & sel_ctrl;
  assign pdata_we_o = req_i & we_i & sel_pdata;
  assign rd_req     = req_i & ~we_i;

  always_comb begin
    rmux = 32'h0;
    if (sel_ctrl)  rmux = ctrl_rd_i;
    if (sel_pdata) rmux = pdata_i;
    if (sel_rdkey) rmux = rdkey_i;
    if (sel_win)   rmux = win_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rmux;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/fusectl_top.sv
module fusectl_top
  import fusectl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned WORDS      = 64,
  parameter int unsigned LAT        = 8,
  parameter int unsigned PROT_FIRST = 32,
  parameter logic [7:0]  SEED       = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic             ctrl_we, pdata_we, start, prog, done;
  logic             rd_busy, wr_busy;
  logic [IDX_W-1:0] op_idx, win_idx;
  logic [31:0]      pdata, rdkey, ctrl_rd, win_data, op_data;
  ctrl_fields_t     fields;

  fusectl_bus #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_bus (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .ctrl_rd_i (ctrl_rd),
    .pdata_i   (pdata),
    .rdkey_i   (rdkey),
    .win_data_i(win_data),
    .ctrl_we_o (ctrl_we),
    .pdata_we_o(pdata_we),
    .win_idx_o (win_idx),
    .rvalid_o,
    .rdata_o
  );

  fusectl_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .ctrl_we_i (ctrl_we),
    .pdata_we_i(pdata_we),
    .wdata_i,
    .done_i    (done),
    .op_data_i (op_data),
    .start_o   (start),
    .prog_o    (prog),
    .idx_o     (op_idx),
    .pdata_o   (pdata),
    .rdkey_o   (rdkey),
    .ctrl_rd_o (ctrl_rd),
    .rd_busy_o (rd_busy),
    .wr_busy_o (wr_busy),
    .fields_o  (fields)
  );

  fusectl_array #(.WORDS(WORDS), .LAT(LAT), .PROT_FIRST(PROT_FIRST), .SEED(SEED)) u_array (
    .clk_i, .rst_ni,
    .win_idx_i (win_idx),
    .win_data_o(win_data),
    .start_i   (start),
    .prog_i    (prog),
    .op_idx_i  (op_idx),
    .pdata_i   (pdata),
    .done_o    (done),
    .op_data_o (op_data)
  );
endmodule

// File: rtl/fusectl_chk.sv
module fusectl_chk
  import fusectl_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORDS  = 64,
  parameter int unsigned LAT    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rvalid_o,
  input logic [31:0]       rdata_o,
  input logic              ctrl_we,
  input logic              rd_busy,
  input logic              wr_busy,
  input logic [15:0]       fields,
  input logic [31:0]       rdkey
);
  logic [31:0] wa, cyc_q;
  logic busy, mapped;
  assign busy   = rd_busy | wr_busy;
  assign wa     = 32'(addr_i[ADDR_W-1:2]);
  assign mapped = (wa == CTRL_OFS / 4) || (wa == PDATA_OFS / 4) || (wa == RDKEY_OFS / 4) ||
                  ((wa >= WIN_OFS / 4) && (wa < WIN_OFS / 4 + WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cyc_q <= '0;
    else if (busy) cyc_q <= cyc_q + 32'd1;
    else           cyc_q <= '0;
  end

  p_onehot_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_busy, wr_busy}));
  p_no_early_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cyc_q != LAT - 1 |=> busy);
  p_clear_on_time_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cyc_q == LAT - 1 |=> !busy);
  p_bad_key_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we && !busy && wdata_i[15:8] != UNLOCK_KEY |=> !busy);
  p_busy_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we && busy |=> $stable(fields));
  p_rdkey_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_busy |=> $stable(rdkey));
  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !mapped |=> rdata_o == 32'h0);
  p_rvalid_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);
  p_rvalid_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

bind fusectl_top fusectl_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LAT(LAT)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rvalid_o, .rdata_o,
  .ctrl_we(ctrl_we), .rd_busy(rd_busy), .wr_busy(wr_busy),
  .fields(fields), .rdkey(rdkey)
);

// File: tb/fusectl_top_bench.sv
module fusectl_top_bench;
  localparam int LAT = 8;
  localparam logic [9:0] A_CTRL = 10'h040, A_PD = 10'h050, A_RK = 10'h060;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid;
  logic [31:0] rdata;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fusectl_top u_fusectl_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  function automatic logic [7:0] exp_byte(int o);
    return 8'((o * 37) % 256) ^ 8'hA5;
  endfunction
  function automatic logic [31:0] exp_word(int w);
    return {exp_byte(4*w+3), exp_byte(4*w+2), exp_byte(4*w+1), exp_byte(4*w)};
  endfunction
  function automatic logic [31:0] mk_ctrl(logic [7:0] ofs, logic [7:0] key, logic rd, logic wr);
    return {8'h00, ofs, key, 6'h00, rd, wr};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic bus_write(logic [9:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R11 no rvalid on write", 32'(rvalid), 32'd0);
  endtask

  task automatic bus_read(logic [9:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    if (!rvalid) chk("R11 rvalid after read", 32'(rvalid), 32'd1);
  endtask

  task automatic poll(output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      bus_read(A_CTRL, v);
      if (v[1:0] == 2'b00) break;
      n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
    bus_read(A_PD, v);   chk("R1 pdata reset", v, 32'h0);
    bus_read(A_RK, v);   chk("R1 rdkey reset", v, 32'h0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    bus_read(10'h200, v); chk("R2 window w0", v, exp_word(0));
    bus_read(10'h214, v); chk("R2 window w5", v, exp_word(5));
    bus_read(10'h27C, v); chk("R2 window w31", v, exp_word(31));
    bus_read(10'h204, v); chk("R2 little-endian low byte", 32'(v[7:0]), 32'(exp_byte(4)));
    bus_read(10'h280, v); chk("R3 protected w32", v, 32'h0);
    bus_read(10'h2FC, v); chk("R3 protected w63", v, 32'h0);
  endtask

  task automatic t_indirect_read();
    logic [31:0] v; int n;
    bus_write(A_CTRL, mk_ctrl(8'hA0, 8'hAC, 1'b1, 1'b0));
    poll(n); chk("R5 busy cycles", 32'(n), 32'(LAT));
    bus_read(A_CTRL, v); chk("R4 field readback", v, mk_ctrl(8'hA0, 8'hAC, 1'b0, 1'b0));
    bus_read(A_RK, v);   chk("R5 protected word 40", v, exp_word(40));
    bus_write(A_CTRL, mk_ctrl(8'h07, 8'hAC, 1'b1, 1'b0));
    poll(n);
    bus_read(A_RK, v);   chk("R5 low offset bits ignored", v, exp_word(1));
  endtask

  task automatic t_bad_key();
    logic [31:0] v;
    bus_write(A_CTRL, mk_ctrl(8'hC0, 8'h12, 1'b1, 1'b1));
    bus_read(A_CTRL, v); chk("R6 request bits zero", v, mk_ctrl(8'hC0, 8'h12, 1'b0, 1'b0));
    repeat (LAT + 2) @(negedge clk);
    bus_read(A_RK, v);   chk("R6 rdkey unchanged", v, exp_word(1));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v; int n;
    bus_write(A_CTRL, mk_ctrl(8'hC8, 8'hAC, 1'b1, 1'b0));
    bus_write(A_CTRL, mk_ctrl(8'h10, 8'hAC, 1'b1, 1'b0));
    poll(n); chk("R7 timing unchanged", 32'(n), 32'(LAT - 1));
    bus_read(A_CTRL, v); chk("R7 fields kept", v, mk_ctrl(8'hC8, 8'hAC, 1'b0, 1'b0));
    bus_read(A_RK, v);   chk("R7 first request data", v, exp_word(50));
  endtask

  task automatic t_program();
    logic [31:0] v; int n;
    bus_write(A_PD, 32'h0F0F_0000);
    bus_read(A_PD, v); chk("R1 pdata readback", v, 32'h0F0F_0000);
    bus_write(A_CTRL, mk_ctrl(8'h28, 8'hAC, 1'b0, 1'b1));
    bus_read(A_CTRL, v); chk("R8 program bit set", 32'(v[1:0]), 32'd1);
    poll(n); chk("R8 busy cycles", 32'(n), 32'(LAT - 1));
    bus_read(10'h228, v); chk("R8 window w10 ORed", v, exp_word(10) | 32'h0F0F_0000);
    bus_write(A_PD, 32'h8000_0001);
    bus_write(A_CTRL, mk_ctrl(8'hB4, 8'hAC, 1'b0, 1'b1));
    poll(n);
    bus_write(A_CTRL, mk_ctrl(8'hB4, 8'hAC, 1'b1, 1'b0));
    poll(n);
    bus_read(A_RK, v); chk("R8 protected w45 ORed", v, exp_word(45) | 32'h8000_0001);
  endtask

  task automatic t_both();
    logic [31:0] v; int n;
    bus_write(A_PD, 32'hFFFF_FFFF);
    bus_write(A_CTRL, mk_ctrl(8'h30, 8'hAC, 1'b1, 1'b1));
    poll(n); chk("R9 busy cycles", 32'(n), 32'(LAT));
    bus_read(10'h230, v); chk("R9 word not programmed", v, exp_word(12));
    bus_read(A_RK, v);    chk("R9 read performed", v, exp_word(12));
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    bus_write(A_RK, 32'hDEAD_BEEF);
    bus_read(A_RK, v);    chk("R10 rdkey write ignored", v, exp_word(12));
    bus_write(10'h204, 32'hFFFF_FFFF);
    bus_read(10'h204, v); chk("R10 window write ignored", v, exp_word(1));
    bus_read(10'h044, v); chk("R10 unmapped 0x44", v, 32'h0);
    bus_read(10'h100, v); chk("R10 unmapped 0x100", v, 32'h0);
    bus_read(10'h3FC, v); chk("R10 unmapped 0x3FC", v, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_indirect_read();
    t_bad_key();
    t_busy_ignore();
    t_program();
    t_both();
    t_ignored();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule